// File: doc/BRIEF.md
# Dual-Resolution System Time Counter

This block keeps the time base for a chip: one wide counter that moves forward once per prescaler tick, where a tick comes every twelve module clocks. Software and neighbouring logic read the counter through two 32-bit views. The fine view has a quarter-microsecond step. The coarse view drops the two lowest bits, which gives a one-microsecond step and a longer range. A one-hot mask picks counter bits to forward to an event network. When more than one mask bit is set, the picked bits are OR-ed together.

The counter waits for an external low-frequency tick before it starts. A sync-pending flag is set out of reset. The first rising edge of the tick clears that flag, realigns the prescaler and starts the counter. Software can set the flag again to realign on a later tick edge. A halt-control bit lets the counter freeze while the debugger holds the core. A single-cycle pulse marks the moment the counter wraps to zero.

Top module: `systime_counter`

## Requirements
- R1: After reset, fine_time_o shows bits [31:0] of the reset count and coarse_time_o shows bits [33:2] of it. sync_busy_o is 1, and running_o, ovf_pulse_o and fwd_bit_o are 0.
- R2: Until the first sync completes, running_o stays 0 and the counter does not move.
- R3: lf_tick_i passes through two synchronizer flops before rising-edge detection. On the third clock edge that samples it high, a pending sync completes: sync_busy_o clears, running_o sets and the prescaler phase returns to zero.
- R4: While running and not frozen, the counter increments by one every 12 clocks. The first increment lands 12 edges after the sync edge.
- R5: fine_time_o equals counter bits [31:0] and coarse_time_o equals counter bits [33:2], for a 34-bit counter.
- R6: With the halt control at 0 (written through halt_wr_i/halt_wdata_i), core_halted_i has no effect on counting.
- R7: With the halt control at 1, every edge with core_halted_i high holds both the prescaler phase and the counter. Counting resumes from the held phase once core_halted_i drops.
- R8: Mask bit i of the 16-bit select forwards counter bit i+2. Several set bits give the OR of the selected bits, and an all-zero mask gives 0. A write takes effect on the edge that latches it.
- R9: ovf_pulse_o is high for exactly the one cycle that follows the edge on which the counter wraps from all ones to zero.
- R10: A sync_wr_i pulse sets sync_busy_o on the next edge, and the next detected tick edge then realigns the prescaler phase. A tick edge seen while no sync is pending leaves the phase unchanged.
- R11: Once set, running_o stays 1 until reset, including through later resyncs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_halted_i | input | 1 | Core held by the debugger |
| lf_tick_i | input | 1 | Asynchronous low-frequency tick |
| halt_wr_i | input | 1 | Write strobe for the halt control |
| halt_wdata_i | input | 1 | Halt control value: 1 freezes while the core is halted |
| bitsel_wr_i | input | 1 | Write strobe for the forward mask |
| bitsel_wdata_i | input | 16 | One-hot forward mask; bit i selects counter bit i+2 |
| sync_wr_i | input | 1 | Requests a resync on the next tick edge |
| fine_time_o | output | 32 | Counter bits [31:0] |
| coarse_time_o | output | 32 | Counter bits [33:2] |
| ovf_pulse_o | output | 1 | One-cycle pulse after the counter wraps |
| fwd_bit_o | output | 1 | OR of the counter bits picked by the mask |
| sync_busy_o | output | 1 | A sync is pending |
| running_o | output | 1 | Timer has synchronized and is counting |

## Verification
Control writes and sync requests show their effect one edge after the strobe. A tick edge acts three edges after lf_tick_i is first sampled high. A count step appears 12 edges after the previous step or after the sync edge, and each frozen edge pushes it out by one edge. The overflow pulse appears on the same edge as the wrap. The bench works out each of these due cycles from the requirements, tags every expected value with its absolute cycle number and compares it at the falling edge of that cycle. It also checks the cycle before a step, so a result that arrives one edge early or late is caught.

// File: rtl/systime_pkg.sv
package systime_pkg;
  localparam int unsigned CNT_W_DEF   = 34;
  localparam int unsigned VIEW_W_DEF  = 32;
  localparam int unsigned DIV_DEF     = 12;
  localparam int unsigned SEL_W_DEF   = 16;
  localparam int unsigned SEL_LSB_DEF = 2;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef struct packed {
    logic busy;
    logic running;
  } sync_state_t;
endpackage

// File: rtl/st_lf_edge.sv
module st_lf_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lf_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], lf_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/st_prescaler.sv
module st_prescaler #(
  parameter int unsigned DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en_i,
  input  logic phase_clr_i,
  output logic tick_o
);
  localparam int unsigned PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            tick;

  always_comb begin
    ph_d = ph_q;
    tick = 1'b0;
    if (phase_clr_i) begin
      ph_d = '0;
    end else if (run_en_i) begin
      if (ph_q == PH_LAST) begin
        ph_d = '0;
        tick = 1'b1;
      end else begin
        ph_d = ph_q + PH_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign tick_o = tick;
endmodule

// File: rtl/st_bit_fwd.sv
module st_bit_fwd #(
  parameter int unsigned SEL_W = 16
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [SEL_W-1:0] win_i,
  output logic             fwd_o
);
  logic [SEL_W-1:0] hit;

  for (genvar i = 0; i < SEL_W; i++) begin : g_hit
    assign hit[i] = sel_i[i] & win_i[i];
  end

  assign fwd_o = |hit;
endmodule

// File: rtl/systime_counter.sv
module systime_counter
  import systime_pkg::*;
#(
  parameter int unsigned CNT_W       = CNT_W_DEF,
  parameter int unsigned VIEW_W      = VIEW_W_DEF,
  parameter int unsigned DIV         = DIV_DEF,
  parameter int unsigned SEL_W       = SEL_W_DEF,
  parameter int unsigned SEL_LSB     = SEL_LSB_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               core_halted_i,
  input  logic               lf_tick_i,
  input  logic               halt_wr_i,
  input  logic               halt_wdata_i,
  input  logic               bitsel_wr_i,
  input  logic [SEL_W-1:0]   bitsel_wdata_i,
  input  logic               sync_wr_i,
  output logic [VIEW_W-1:0]  fine_time_o,
  output logic [VIEW_W-1:0]  coarse_time_o,
  output logic               ovf_pulse_o,
  output logic               fwd_bit_o,
  output logic               sync_busy_o,
  output logic               running_o
);
  localparam int unsigned COARSE_SHIFT = CNT_W - VIEW_W;

  logic             halt_q, halt_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  sync_state_t      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;

  logic lf_rise, sync_hit, freeze, cnt_en, tick;

  st_lf_edge #(.STAGES(SYNC_STAGES)) u_lf_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lf_i   (lf_tick_i),
    .rise_o (lf_rise)
  );

  assign freeze   = halt_q & core_halted_i;
  assign sync_hit = lf_rise & st_q.busy;
  assign cnt_en   = st_q.running & ~freeze;

  st_prescaler #(.DIV(DIV)) u_presc (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en_i    (cnt_en),
    .phase_clr_i (sync_hit),
    .tick_o      (tick)
  );

  st_bit_fwd #(.SEL_W(SEL_W)) u_fwd (
    .sel_i (sel_q),
    .win_i (cnt_q[SEL_LSB +: SEL_W]),
    .fwd_o (fwd_bit_o)
  );

  always_comb begin
    halt_d = halt_wr_i   ? halt_wdata_i   : halt_q;
    sel_d  = bitsel_wr_i ? bitsel_wdata_i : sel_q;

    st_d = st_q;
    if (sync_wr_i)     st_d.busy = 1'b1;
    else if (sync_hit) st_d.busy = 1'b0;
    if (sync_hit)      st_d.running = 1'b1;

    cnt_d = tick ? (cnt_q + CNT_W'(1)) : cnt_q;
    ovf_d = tick & (&cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      sel_q  <= '0;
      st_q   <= '{busy: 1'b1, running: 1'b0};
      cnt_q  <= CNT_INIT;
      ovf_q  <= 1'b0;
    end else begin
      halt_q <= halt_d;
      sel_q  <= sel_d;
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
    end
  end

  assign fine_time_o   = cnt_q[VIEW_W-1:0];
  assign coarse_time_o = cnt_q[COARSE_SHIFT +: VIEW_W];
  assign ovf_pulse_o   = ovf_q;
  assign sync_busy_o   = st_q.busy;
  assign running_o     = st_q.running;
endmodule

// File: rtl/systime_counter_chk.sv
module systime_counter_chk #(
  parameter int unsigned VIEW_W       = 32,
  parameter int unsigned SEL_W        = 16,
  parameter int unsigned COARSE_SHIFT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_halted_i,
  input logic              halt_en,
  input logic [SEL_W-1:0]  sel_mask,
  input logic [VIEW_W-1:0] fine_time_o,
  input logic [VIEW_W-1:0] coarse_time_o,
  input logic              ovf_pulse_o,
  input logic              fwd_bit_o,
  input logic              sync_busy_o,
  input logic              running_o
);
  a_r2_hold_before_run: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o |=> $stable(fine_time_o));

  a_r3_run_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running_o) |-> !sync_busy_o);

  a_r4_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fine_time_o) |-> fine_time_o == VIEW_W'($past(fine_time_o) + 1));

  a_r5_views_agree: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_time_o[VIEW_W-COARSE_SHIFT-1:0] == fine_time_o[VIEW_W-1:COARSE_SHIFT]);

  a_r7_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_en && core_halted_i) |=> $stable(fine_time_o));

  a_r8_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_mask == '0) |-> !fwd_bit_o);

  a_r9_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse_o |=> !ovf_pulse_o);

  a_r9_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse_o |-> (fine_time_o == '0 && coarse_time_o == '0));

  a_r11_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    running_o |=> running_o);
endmodule

bind systime_counter systime_counter_chk #(
  .VIEW_W(VIEW_W), .SEL_W(SEL_W), .COARSE_SHIFT(COARSE_SHIFT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .core_halted_i (core_halted_i),
  .halt_en       (halt_q),
  .sel_mask      (sel_q),
  .fine_time_o   (fine_time_o),
  .coarse_time_o (coarse_time_o),
  .ovf_pulse_o   (ovf_pulse_o),
  .fwd_bit_o     (fwd_bit_o),
  .sync_busy_o   (sync_busy_o),
  .running_o     (running_o)
);

// File: tb/systime_counter_tb_top.sv
module systime_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int K_FINE = 0, K_COARSE = 1, K_OVF = 2, K_FWD = 3, K_BUSY = 4, K_RUN = 5;

  typedef struct {
    int          due;
    int          kind;
    logic [31:0] exp;
    string       req;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_halted = 1'b0, lf_tick = 1'b0;
  logic        halt_wr = 1'b0, halt_wdata = 1'b0;
  logic        bitsel_wr = 1'b0;
  logic [15:0] bitsel_wdata = '0;
  logic        sync_wr = 1'b0;
  logic [31:0] fine_time, coarse_time;
  logic        ovf_pulse, fwd_bit, sync_busy, running;

  int       cyc = 0;
  int       checks = 0, failures = 0;
  bit       done = 1'b0;
  sb_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  systime_counter #(.CNT_INIT(34'h3_FFFF_FFF8)) dut_i (
    .clk(clk), .rst_n(rst_n), .core_halted_i(core_halted), .lf_tick_i(lf_tick),
    .halt_wr_i(halt_wr), .halt_wdata_i(halt_wdata),
    .bitsel_wr_i(bitsel_wr), .bitsel_wdata_i(bitsel_wdata), .sync_wr_i(sync_wr),
    .fine_time_o(fine_time), .coarse_time_o(coarse_time), .ovf_pulse_o(ovf_pulse),
    .fwd_bit_o(fwd_bit), .sync_busy_o(sync_busy), .running_o(running)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  function automatic logic [31:0] actual_of(int kind);
    case (kind)
      K_FINE:   return fine_time;
      K_COARSE: return coarse_time;
      K_OVF:    return {31'd0, ovf_pulse};
      K_FWD:    return {31'd0, fwd_bit};
      K_BUSY:   return {31'd0, sync_busy};
      default:  return {31'd0, running};
    endcase
  endfunction

  // monitor: compares every item due in the current cycle
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = sb_q.size() - 1; i >= 0; i--) begin
        if (sb_q[i].due == cyc) begin
          checks++;
          if (actual_of(sb_q[i].kind) !== sb_q[i].exp) begin
            failures++;
            $display("FAIL %s cyc=%0d kind=%0d actual=%h expected=%h",
                     sb_q[i].req, cyc, sb_q[i].kind, actual_of(sb_q[i].kind), sb_q[i].exp);
          end
          sb_q.delete(i);
        end
      end
    end
  end

  task automatic expect_at(int due, int kind, logic [31:0] v, string req);
    sb_q.push_back('{due: due, kind: kind, exp: v, req: req});
  endtask

  task automatic wait_cyc(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic write_sel(int c, logic [15:0] v);
    wait_cyc(c);
    bitsel_wr = 1'b1; bitsel_wdata = v;
    @(negedge clk);
    bitsel_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      if (sb_q.size() != 0) begin
        failures++;
        $display("FAIL scoreboard cyc=%0d actual=%0d expected=0 pending items", cyc, sb_q.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    $display("FAIL watchdog cyc=%0d actual=running expected=finished", cyc);
    finish_run();
  end

  initial begin
    int s;
    // R1 reset state; R8 zero mask with counter bit3 set
    expect_at(1, K_FINE,   32'hFFFF_FFF8, "R1");
    expect_at(1, K_COARSE, 32'hFFFF_FFFE, "R1");
    expect_at(1, K_BUSY,   32'd1, "R1");
    expect_at(1, K_RUN,    32'd0, "R1");
    expect_at(1, K_OVF,    32'd0, "R1");
    expect_at(1, K_FWD,    32'd0, "R8");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 forwarding against a static count 0x...F8
    expect_at(6,  K_FWD, 32'd0, "R8");
    expect_at(9,  K_FWD, 32'd1, "R8");
    expect_at(12, K_FWD, 32'd1, "R8");
    expect_at(15, K_FWD, 32'd0, "R8");
    expect_at(18, K_FWD, 32'd0, "R8");
    write_sel(5,  16'h0001);
    write_sel(8,  16'h0003);
    write_sel(11, 16'h8000);
    write_sel(14, 16'h0000);
    write_sel(17, 16'h0001);

    // R2 no movement before sync
    expect_at(30, K_FINE, 32'hFFFF_FFF8, "R2");
    expect_at(30, K_RUN,  32'd0, "R2");

    // R3 first sync: tick raised at cyc 40, acts on edge 43
    s = 43;
    expect_at(s-1, K_BUSY, 32'd1, "R3");
    expect_at(s-1, K_RUN,  32'd0, "R3");
    expect_at(s,   K_BUSY, 32'd0, "R3");
    expect_at(s,   K_RUN,  32'd1, "R3");
    expect_at(s+11, K_FINE, 32'hFFFF_FFF8, "R4");
    expect_at(s+12, K_FINE, 32'hFFFF_FFF9, "R4");
    expect_at(s+24, K_FINE, 32'hFFFF_FFFA, "R6");
    expect_at(s+24, K_COARSE, 32'hFFFF_FFFE, "R5");
    expect_at(s+40, K_FINE, 32'hFFFF_FFFA, "R7");
    expect_at(s+55, K_FINE, 32'hFFFF_FFFA, "R7");
    expect_at(s+56, K_FINE, 32'hFFFF_FFFB, "R7");
    expect_at(s+62, K_BUSY, 32'd0, "R10");
    expect_at(s+67, K_FINE, 32'hFFFF_FFFB, "R10");
    expect_at(s+68, K_FINE, 32'hFFFF_FFFC, "R10");
    expect_at(s+68, K_COARSE, 32'hFFFF_FFFF, "R5");
    expect_at(s+100, K_RUN, 32'd1, "R11");
    expect_at(s+104, K_FINE, 32'hFFFF_FFFF, "R5");
    expect_at(s+104, K_COARSE, 32'hFFFF_FFFF, "R5");
    expect_at(s+115, K_OVF, 32'd0, "R9");
    expect_at(s+116, K_OVF, 32'd1, "R9");
    expect_at(s+116, K_FINE, 32'd0, "R9");
    expect_at(s+116, K_COARSE, 32'd0, "R9");
    expect_at(s+117, K_OVF, 32'd0, "R9");
    expect_at(s+163, K_FWD, 32'd0, "R8");
    expect_at(s+164, K_FWD, 32'd1, "R8");
    expect_at(s+171, K_BUSY, 32'd1, "R10");
    expect_at(s+182, K_BUSY, 32'd1, "R10");
    expect_at(s+183, K_BUSY, 32'd0, "R10");
    expect_at(s+183, K_RUN,  32'd1, "R11");
    expect_at(s+188, K_FINE, 32'd5, "R10");
    expect_at(s+194, K_FINE, 32'd5, "R10");
    expect_at(s+195, K_FINE, 32'd6, "R10");
    expect_at(s+207, K_FINE, 32'd7, "R4");

    wait_cyc(40);    lf_tick = 1'b1;
    wait_cyc(s+5);   lf_tick = 1'b0;
    wait_cyc(s+13);  core_halted = 1'b1;          // R6: halt control still 0
    wait_cyc(s+25);  core_halted = 1'b0; halt_wr = 1'b1; halt_wdata = 1'b1;
    @(negedge clk);  halt_wr = 1'b0;
    wait_cyc(s+30);  core_halted = 1'b1;          // R7: freeze edges s+31..s+50
    wait_cyc(s+50);  core_halted = 1'b0;
    wait_cyc(s+58);  lf_tick = 1'b1;              // R10: edge with no sync pending
    wait_cyc(s+140); lf_tick = 1'b0;
    wait_cyc(s+170); sync_wr = 1'b1;
    @(negedge clk);  sync_wr = 1'b0;
    wait_cyc(s+180); lf_tick = 1'b1;              // R10: resync on edge s+183
    wait_cyc(s+215);
    finish_run();
  end
endmodule